// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is an integer arithmetic and logic unit of parameterizable width W, with a default of 16 bits and a minimum of 8. It takes two operands `a` and `b` and a 4-bit operation code. It drives the result combinationally in the same cycle.

Six status flags are held in a register: zero, sign, carry, overflow, parity and auxiliary carry. That register loads the next flag values on a rising clock edge only when `valid` is high.

Add-with-carry and subtract-with-borrow take their carry-in from the stored carry flag. A wide sum therefore comes from issuing the low word with a plain add and then the high word with an add-with-carry. Increment and decrement keep the stored carry, so a loop counter can run between the steps of a multi-word chain without breaking it.

Top module: `int_alu`

## Requirements
- R1: The `op` encoding is as follows:
  - 0 add, `a+b`
  - 1 subtract, `a-b`
  - 2 add-with-carry
  - 3 subtract-with-borrow
  - 4 increment, `a+1`
  - 5 decrement, `a-1`
  - 6 negate
  - 7 AND
  - 8 OR
  - 9 XOR
  - 10 NOT
  - 11 shift left
  - 12 logical shift right
  - 13 arithmetic shift right
  - 14 rotate left
  - 15 rotate right

  Operations 4, 5, 6, 10 and 11 to 15 use `a` only. The result wraps modulo 2^W. For add, the carry flag is the unsigned carry out. For subtract, the carry flag is set when `a < b` unsigned.
- R2: The overflow flag is set on signed overflow of add, subtract, increment, decrement and negate. For example, 0x7FFF+1 gives 0x8000 with overflow set and carry clear.
- R3: Every operation except NOT sets the zero flag when the result is 0 and copies the result's MSB into the sign flag.
- R4: Every operation except NOT sets the parity flag when bits 7:0 of the result hold an even number of ones.
- R5: For arithmetic operations, the auxiliary flag is set on a carry or borrow across bit 3 into bit 4.
- R6: Increment and decrement update zero, sign, overflow, parity and auxiliary, but leave the carry flag at its stored value.
- R7: Add-with-carry adds the stored carry flag as a carry-in. Subtract-with-borrow subtracts it as a borrow-in. An add followed by an add-with-carry on the high words yields the 2W-bit sum.
- R8: Negate yields the two's complement `0-a`, with carry set when `a` is not 0. NOT yields `~a` and leaves all six flags unchanged.
- R9: AND, OR and XOR clear the carry, overflow and auxiliary flags.
- R10: Shifts and rotates move by one bit, and the carry flag takes the bit shifted or rotated out. Arithmetic shift right replicates the MSB. The overflow flag depends on the operation:
  - shift left and rotate left: result MSB XOR new carry
  - logical shift right: the original MSB of `a`
  - arithmetic shift right: 0
  - rotate right: XOR of the result's two top bits

  The auxiliary flag is cleared.
- R11: The flags change only on a rising edge with `valid` high. An active-low reset clears all six flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| valid | input | 1 | Loads the flag register on this edge |
| op | input | 4 | Operation code (see R1) |
| a | input | W | First operand |
| b | input | W | Second operand |
| result | output | W | Combinational result |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_c | output | 1 | Carry / borrow flag |
| flag_o | output | 1 | Signed overflow flag |
| flag_p | output | 1 | Parity of the low byte |
| flag_a | output | 1 | Auxiliary carry across bit 3 |

## Verification
The bench goes after the wrap points, where an ALU most often goes wrong.

- **0x7FFF+1 and 0xFFFF+1.** These separate overflow from carry. An ALU that swaps the two reports the wrong kind of overflow.
- **Negate of 0x8000.** This must raise overflow while leaving the value unchanged.
- **Increment of 0xFFFF after a cleared carry, and decrement after a set carry.** These catch an increment or decrement that lets the adder's carry leak into the carry flag.
- **A 32-bit chained add.** This fails when add-with-carry ignores the stored flag.
- **Subtract-with-borrow.** This fails when the stored flag is added where it should be subtracted.
- **Shifts and rotates on values with both end bits set.** These expose a carry taken from the wrong end.
- **Operation issued with `valid` low, and NOT.** Both must leave every flag unchanged. A design that updates flags unconditionally would overwrite them.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_c,
  output logic         flag_o,
  output logic         flag_p,
  output logic         flag_a
);
  localparam int MSB = W - 1;

  localparam logic [3:0] OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_ADC = 4'd2,  OP_SBB = 4'd3;
  localparam logic [3:0] OP_INC = 4'd4,  OP_DEC = 4'd5,  OP_NEG = 4'd6,  OP_AND = 4'd7;
  localparam logic [3:0] OP_OR  = 4'd8,  OP_XOR = 4'd9,  OP_NOT = 4'd10, OP_SHL = 4'd11;
  localparam logic [3:0] OP_SHR = 4'd12, OP_SAR = 4'd13, OP_ROL = 4'd14, OP_ROR = 4'd15;

  logic [W-1:0] x, y;
  logic         cin, is_sub;
  logic [W:0]   sum_ext;
  logic         c_nx, o_nx, a_nx, keep_all;

  always_comb begin
    x      = a;
    y      = b;
    cin    = 1'b0;
    is_sub = 1'b0;
    unique case (op)
      OP_SUB:  is_sub = 1'b1;
      OP_ADC:  cin = flag_c;
      OP_SBB:  begin is_sub = 1'b1; cin = flag_c; end
      OP_INC:  y = W'(1);
      OP_DEC:  begin y = W'(1); is_sub = 1'b1; end
      OP_NEG:  begin x = '0; y = a; is_sub = 1'b1; end
      default: ;
    endcase
  end

  assign sum_ext = is_sub ? ({1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin})
                          : ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin});

  wire arith_o = is_sub ? ((x[MSB] != y[MSB]) && (sum_ext[MSB] != x[MSB]))
                        : ((x[MSB] == y[MSB]) && (sum_ext[MSB] != x[MSB]));
  wire arith_a = x[4] ^ y[4] ^ sum_ext[4];

  always_comb begin
    result   = sum_ext[W-1:0];
    c_nx     = sum_ext[W];
    o_nx     = arith_o;
    a_nx     = arith_a;
    keep_all = 1'b0;
    unique case (op)
      OP_INC, OP_DEC: c_nx = flag_c;
      OP_AND: begin result = a & b; c_nx = 1'b0; o_nx = 1'b0; a_nx = 1'b0; end
      OP_OR:  begin result = a | b; c_nx = 1'b0; o_nx = 1'b0; a_nx = 1'b0; end
      OP_XOR: begin result = a ^ b; c_nx = 1'b0; o_nx = 1'b0; a_nx = 1'b0; end
      OP_NOT: begin result = ~a; keep_all = 1'b1; end
      OP_SHL: begin
        result = {a[MSB-1:0], 1'b0}; c_nx = a[MSB];
        o_nx = a[MSB-1] ^ a[MSB]; a_nx = 1'b0;
      end
      OP_SHR: begin
        result = {1'b0, a[MSB:1]}; c_nx = a[0]; o_nx = a[MSB]; a_nx = 1'b0;
      end
      OP_SAR: begin
        result = {a[MSB], a[MSB:1]}; c_nx = a[0]; o_nx = 1'b0; a_nx = 1'b0;
      end
      OP_ROL: begin
        result = {a[MSB-1:0], a[MSB]}; c_nx = a[MSB];
        o_nx = a[MSB-1] ^ a[MSB]; a_nx = 1'b0;
      end
      OP_ROR: begin
        result = {a[0], a[MSB:1]}; c_nx = a[0];
        o_nx = a[0] ^ a[MSB]; a_nx = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_z <= 1'b0; flag_s <= 1'b0; flag_c <= 1'b0;
      flag_o <= 1'b0; flag_p <= 1'b0; flag_a <= 1'b0;
    end else if (valid && !keep_all) begin
      flag_z <= (result == '0);
      flag_s <= result[MSB];
      flag_c <= c_nx;
      flag_o <= o_nx;
      flag_p <= ~^result[7:0];
      flag_a <= a_nx;
    end
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid,
  input logic [3:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] result,
  input logic         flag_z,
  input logic         flag_s,
  input logic         flag_c,
  input logic         flag_o,
  input logic         flag_p,
  input logic         flag_a
);
  wire [5:0] flags = {flag_a, flag_p, flag_o, flag_c, flag_s, flag_z};

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(flags));

  assert_not_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == 4'd10) |=> $stable(flags));

  assert_incdec_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (op == 4'd4 || op == 4'd5)) |=> flag_c == $past(flag_c));

  assert_logic_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (op == 4'd7 || op == 4'd8 || op == 4'd9)) |=> (!flag_c && !flag_o && !flag_a));

  assert_zero_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op != 4'd10) |=> (flag_z == ($past(result) == '0)) && (flag_s == $past(result[W-1])));

  assert_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op != 4'd10) |=> flag_p == ~^$past(result[7:0]));

  assert_sar_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd13) |-> result[W-1] == a[W-1]);
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .a(a), .result(result),
  .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c),
  .flag_o(flag_o), .flag_p(flag_p), .flag_a(flag_a)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int W = 16;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [3:0] op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] result;
  logic flag_z, flag_s, flag_c, flag_o, flag_p, flag_a;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  int_alu #(.W(W)) u_int_alu (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .a(a), .b(b),
    .result(result), .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c),
    .flag_o(flag_o), .flag_p(flag_p), .flag_a(flag_a)
  );

  // op, a, b, expected result, expected flags {a,p,o,c,s,z}; run in order (carry chains)
  localparam logic [57:0] VEC [NV] = '{
    {4'd0,  16'h7FFF, 16'h0001, 16'h8000, 6'b111010},  // R2
    {4'd0,  16'hFFFF, 16'h0001, 16'h0000, 6'b110101},  // R1
    {4'd2,  16'h0001, 16'h0002, 16'h0004, 6'b000000},  // R7
    {4'd1,  16'h0003, 16'h0005, 16'hFFFE, 6'b100110},  // R1 borrow
    {4'd3,  16'h0010, 16'h0000, 16'h000F, 6'b110000},  // R7 sbb
    {4'd4,  16'hFFFF, 16'h1234, 16'h0000, 6'b110001},  // R6 inc keeps C=0
    {4'd1,  16'h0000, 16'h0001, 16'hFFFF, 6'b110110},  // R5
    {4'd5,  16'h8000, 16'h0000, 16'h7FFF, 6'b111100},  // R6 dec keeps C=1
    {4'd6,  16'h0001, 16'h0000, 16'hFFFF, 6'b110110},  // R8
    {4'd6,  16'h8000, 16'h0000, 16'h8000, 6'b011110},  // R8/R2
    {4'd7,  16'hF0F0, 16'h0FF0, 16'h00F0, 6'b010000},  // R9
    {4'd8,  16'h8000, 16'h0001, 16'h8001, 6'b000010},  // R9
    {4'd9,  16'h5A5A, 16'h5A5A, 16'h0000, 6'b010001},  // R9/R3
    {4'd10, 16'h00FF, 16'h0000, 16'hFF00, 6'b010001},  // R8 flags kept
    {4'd11, 16'h8001, 16'h0000, 16'h0002, 6'b001100},  // R10
    {4'd12, 16'h0003, 16'h0000, 16'h0001, 6'b000100},  // R10
    {4'd13, 16'h8002, 16'h0000, 16'hC001, 6'b000010},  // R10
    {4'd14, 16'h8001, 16'h0000, 16'h0003, 6'b011100},  // R10
    {4'd15, 16'h0001, 16'h0000, 16'h8000, 6'b011110},  // R10
    {4'd0,  16'h0008, 16'h0008, 16'h0010, 6'b100000}   // R5/R4
  };

  function automatic logic [5:0] flags_now();
    return {flag_a, flag_p, flag_o, flag_c, flag_s, flag_z};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    valid = v; op = o; a = x; b = y;
    #5;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset flags", {10'd0, flags_now()}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VEC[i][57:54], VEC[i][53:38], VEC[i][37:22]);
      check($sformatf("R1 result vec%0d", i), result, VEC[i][21:6]);
      #10;
      check($sformatf("R3 flags vec%0d", i), {10'd0, flags_now()}, {10'd0, VEC[i][5:0]});
    end

    // R11: valid low must not touch flags (last were 100000)
    issue(1'b0, 4'd0, 16'hFFFF, 16'h0001);
    check("R1 result with valid low", result, 16'h0000);
    #10;
    check("R11 flags held with valid low", {10'd0, flags_now()}, {10'd0, 6'b100000});

    // R7: 32-bit chain 0x0001FFFF + 0x00000001 = 0x00020000
    issue(1'b1, 4'd0, 16'hFFFF, 16'h0001);
    check("R7 low word", result, 16'h0000);
    #10;
    check("R7 carry out of low word", {15'd0, flag_c}, 16'd1);
    issue(1'b1, 4'd2, 16'h0001, 16'h0000);
    check("R7 high word", result, 16'h0002);
    #10;
    check("R7 carry after high word", {15'd0, flag_c}, 16'd0);

    // R6: increment of 0x7FFF sets overflow, keeps carry 0
    issue(1'b1, 4'd4, 16'h7FFF, 16'h0000);
    check("R6 inc result", result, 16'h8000);
    #10;
    check("R6 inc flags", {10'd0, flags_now()}, {10'd0, 6'b111010});

    // R11: reset in mid-run clears flags
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b0;
    #5;
    check("R11 async reset", {10'd0, flags_now()}, '0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule